// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits between the host write port of a paged non-volatile memory and its page-load controller. Every accepted host write (address plus data byte) passes through it. It recognises two fixed address/data command sequences. A three-write sequence arms protection and unlocks the current load. A six-write sequence removes protection. Command writes never reach the page buffer. Ordinary data writes are forwarded to the page buffer only when protection is off or when the current load was opened by a command sequence.

Writes are grouped into load phases. A phase starts with the first accepted write and closes once a programmable number of clock edges has passed with no further write. When a phase closes, the block starts the programming timer of the page controller. It either requests a commit, because bytes were stored, or a timer run that stores nothing. A change of protection takes effect only when the page controller reports the end of that programming cycle. The host write port is valid/ready. `wr_ready` is low from the close of a phase until `cycle_done`, and a write is accepted only on an edge where both `wr_valid` and `wr_ready` are high. The host must hold its address and data stable until that edge. The store stream towards the page buffer is valid-only, one byte per accepted write, and has no back-pressure.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset `prot_on` is 0, `wr_ready` is 1, and `st_valid`, `commit_start` and `blind_start` are 0.
- R2: With protection off, an accepted data write raises `st_valid` in the next cycle for one cycle, carrying the write's address and data.
- R3: A write that matches the expected step of a command sequence is never stored. The arming sequence, written as the first writes of a phase, is 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Data writes that follow it in the same phase are stored even while protection is on.
- R4: After the arming sequence, `prot_on` stays at its old value through the whole programming cycle and becomes 1 in the cycle after `cycle_done`. This holds even when no data followed the sequence.
- R5: The removal sequence, written as the first writes of a phase, is 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, then 0x20 to 0x5555. None of these writes is stored. `prot_on` drops to 0 in the cycle after the `cycle_done` that ends that phase's cycle.
- R6: While protection is on, a phase that does not open with the arming sequence stores nothing, and its close raises `blind_start`.
- R7: A phase closes on the LOAD_WIN-th consecutive clock edge with no accepted write, and the start pulse is visible in the following cycle. A write accepted on exactly that edge keeps the phase open.
- R8: A phase that closes partway through a sequence discards the partial match. The next phase starts matching from its first write.
- R9: A write that does not match the expected step ends matching for the phase and is handled as an ordinary data byte. It is stored when protection is off or the phase is unlocked, and is dropped otherwise.
- R10: `wr_ready` is 0 from the cycle of the start pulse until the cycle after `cycle_done`. A held `wr_valid` in that time stores nothing. A `cycle_done` while no cycle runs changes nothing.
- R11: Each phase close raises exactly one one-cycle pulse. The pulse is `commit_start` if the phase stored at least one byte, and `blind_start` otherwise.
- R12: Sequences are recognised only from the first write of a phase. A command-shaped write after a data write in the same phase is data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Block can accept a write this cycle |
| wr_addr | input | AW (15) | Host write address |
| wr_data | input | DW (8) | Host write data |
| cycle_done | input | 1 | Page controller: programming cycle finished |
| prot_on | output | 1 | Protection state |
| st_valid | output | 1 | Store byte into page buffer |
| st_addr | output | AW (15) | Address of byte to store |
| st_data | output | DW (8) | Byte to store |
| commit_start | output | 1 | Start programming timer, commit page |
| blind_start | output | 1 | Start programming timer, store nothing |

## Verification
The delicate coincidence is a host write arriving on the very edge at which the load window would expire. The bench provokes it by waiting exactly LOAD_WIN-1 idle edges after a write and then presenting the next one. It judges the outcome by confirming that the second byte is stored and that only one start pulse follows, LOAD_WIN edges after that byte. A second coincidence is a request held on `wr_valid` in the cycle that `cycle_done` reopens the port. The bench checks that nothing is stored while the port is closed, and that a stray `cycle_done` outside a cycle leaves protection and readiness unchanged.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_S1, M_S2, M_S3, M_S4, M_S5, M_DATA, M_OPEN
  } mstate_t;

  localparam logic [14:0] ADR_HI   = 15'h5555;
  localparam logic [14:0] ADR_LO   = 15'h2AAA;
  localparam logic [7:0]  B_KEY1   = 8'hAA;
  localparam logic [7:0]  B_KEY2   = 8'h55;
  localparam logic [7:0]  B_ARM    = 8'hA0;
  localparam logic [7:0]  B_PREFIX = 8'h80;
  localparam logic [7:0]  B_DROP   = 8'h20;
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          phase_close,
  output logic          is_cmd,
  output logic          unlocked,
  output logic          en_hit,
  output logic          dis_hit
);
  mstate_t state, nxt;
  logic hi, lo;

  assign hi = (addr == AW'(ADR_HI));
  assign lo = (addr == AW'(ADR_LO));

  always_comb begin
    nxt     = state;
    is_cmd  = 1'b0;
    en_hit  = 1'b0;
    dis_hit = 1'b0;
    if (fire) begin
      nxt = M_DATA;
      case (state)
        M_IDLE: if (hi && data == DW'(B_KEY1)) begin nxt = M_S1; is_cmd = 1'b1; end
        M_S1:   if (lo && data == DW'(B_KEY2)) begin nxt = M_S2; is_cmd = 1'b1; end
        M_S2: begin
          if (hi && data == DW'(B_ARM)) begin
            nxt = M_OPEN; is_cmd = 1'b1; en_hit = 1'b1;
          end else if (hi && data == DW'(B_PREFIX)) begin
            nxt = M_S3; is_cmd = 1'b1;
          end
        end
        M_S3:   if (hi && data == DW'(B_KEY1)) begin nxt = M_S4; is_cmd = 1'b1; end
        M_S4:   if (lo && data == DW'(B_KEY2)) begin nxt = M_S5; is_cmd = 1'b1; end
        M_S5: begin
          if (hi && data == DW'(B_DROP)) begin
            nxt = M_OPEN; is_cmd = 1'b1; dis_hit = 1'b1;
          end
        end
        M_OPEN:  nxt = M_OPEN;
        default: nxt = M_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state <= M_IDLE;
    else if (phase_close) state <= M_IDLE;
    else if (fire)        state <= nxt;
  end

  assign unlocked = (state == M_OPEN);

  // R3/R5: a completed sequence always leaves the matcher unlocked
  p_hit_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hit || dis_hit) |=> (state == M_OPEN));
  // R8: a closed phase restarts matching from idle
  p_close_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_close |=> (state == M_IDLE));
endmodule

// File: rtl/wp_load_window.sv
module wp_load_window #(
  parameter int LOAD_WIN = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic close
);
  localparam int CW = (LOAD_WIN > 2) ? $clog2(LOAD_WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOAD_WIN - 1);

  logic          active;
  logic [CW-1:0] cnt;

  assign close = active && !fire && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (fire) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (close) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt    <= cnt + 1'b1;
    end
  end

  // R7: the window never closes while idle
  p_close_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !active);
endmodule

// File: rtl/wp_prot_ctl.sv
module wp_prot_ctl #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          close,
  input  logic          en_hit,
  input  logic          dis_hit,
  input  logic          cycle_done,
  output logic          prot_on,
  output logic          busy,
  output logic          st_valid,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          commit_start,
  output logic          blind_start
);
  logic stored_any, pend_set, pend_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid     <= 1'b0;
      st_addr      <= '0;
      st_data      <= '0;
      stored_any   <= 1'b0;
      commit_start <= 1'b0;
      blind_start  <= 1'b0;
      busy         <= 1'b0;
      pend_set     <= 1'b0;
      pend_clr     <= 1'b0;
      prot_on      <= 1'b0;
    end else begin
      st_valid     <= store;
      if (store) begin
        st_addr <= addr;
        st_data <= data;
      end
      commit_start <= close && stored_any;
      blind_start  <= close && !stored_any;
      if (close)      stored_any <= 1'b0;
      else if (store) stored_any <= 1'b1;
      if (en_hit)  pend_set <= 1'b1;
      if (dis_hit) pend_clr <= 1'b1;
      if (close) begin
        busy <= 1'b1;
      end else if (cycle_done && busy) begin
        busy     <= 1'b0;
        pend_set <= 1'b0;
        pend_clr <= 1'b0;
        if (pend_set)      prot_on <= 1'b1;
        else if (pend_clr) prot_on <= 1'b0;
      end
    end
  end

  // R4/R5: protection moves only on the end of a programming cycle
  p_prot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> $stable(prot_on));
  // R11: the two start pulses never coincide
  p_start_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_start, blind_start}));
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int LOAD_WIN = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cycle_done,
  output logic          prot_on,
  output logic          st_valid,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          commit_start,
  output logic          blind_start
);
  logic fire, close, is_cmd, unlocked, en_hit, dis_hit, store, busy;

  assign wr_ready = !busy;
  assign fire     = wr_valid && wr_ready;
  assign store    = fire && !is_cmd && (unlocked || !prot_on);

  wp_seq_match #(.AW(AW), .DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr(wr_addr), .data(wr_data),
    .phase_close(close), .is_cmd(is_cmd), .unlocked(unlocked),
    .en_hit(en_hit), .dis_hit(dis_hit)
  );

  wp_load_window #(.LOAD_WIN(LOAD_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .fire(fire), .close(close)
  );

  wp_prot_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .store(store), .addr(wr_addr), .data(wr_data),
    .close(close), .en_hit(en_hit), .dis_hit(dis_hit), .cycle_done(cycle_done),
    .prot_on(prot_on), .busy(busy), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .commit_start(commit_start), .blind_start(blind_start)
  );

  // R3: a command write is never forwarded to the page buffer
  p_cmd_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_cmd) |=> !st_valid);
  // R10: a request refused by back-pressure stores nothing
  p_refused_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> !st_valid);
  // R2/R7: a stored byte and a phase-close pulse never share a cycle
  p_store_vs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !(commit_start || blind_start));
endmodule

// File: tb/tb_wp_seq_guard.sv
`timescale 1ns/1ps
module tb_wp_seq_guard;
  localparam int AW = 15, DW = 8, WIN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, cycle_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, prot_on, st_valid, commit_start, blind_start;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;

  int checks = 0, failures = 0, n_start = 0, cyc = 0;

  always #2 clk = ~clk;

  wp_seq_guard #(.AW(AW), .DW(DW), .LOAD_WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .cycle_done(cycle_done),
    .prot_on(prot_on), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .commit_start(commit_start), .blind_start(blind_start)
  );

  always @(negedge clk) if (commit_start || blind_start) n_start++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit exp_st, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    chk(st_valid == exp_st, {tag, " store flag"}, st_valid, exp_st);
    if (exp_st && st_valid)
      chk(st_addr == a && st_data == d, {tag, " store addr/data"},
          {st_addr, st_data}, {a, d});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic close_chk(input bit exp_commit, input string tag);
    int k;
    k = 0;
    for (int i = 1; i <= 3 * WIN; i++) begin
      @(posedge clk); #1;
      if (commit_start || blind_start) begin k = i; break; end
    end
    chk(k == WIN, {tag, " R7 close edge"}, k, WIN);
    chk(commit_start == exp_commit && blind_start == !exp_commit,
        {tag, " R11 pulse kind"}, {commit_start, blind_start}, {exp_commit, !exp_commit});
    chk(wr_ready == 1'b0, {tag, " R10 ready low"}, wr_ready, 0);
    @(posedge clk); #1;
    chk(!commit_start && !blind_start, {tag, " R11 single pulse"},
        {commit_start, blind_start}, 0);
  endtask

  task automatic done_pulse();
    @(negedge clk); cycle_done = 1'b1;
    @(posedge clk); #1; cycle_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(prot_on == 0 && wr_ready == 1, "R1 reset prot/ready", {prot_on, wr_ready}, 2'b01);
    chk(!st_valid && !commit_start && !blind_start, "R1 reset pulses",
        {st_valid, commit_start, blind_start}, 0);
  endtask

  task automatic t_plain();
    wr(15'h0010, 8'h11, 1, "R2 plain b0");
    wr(15'h0011, 8'h22, 1, "R2 plain b1");
    close_chk(1, "R2 plain");
    done_pulse();
    chk(wr_ready == 1 && prot_on == 0, "R10 ready after done", {wr_ready, prot_on}, 2'b10);
  endtask

  task automatic t_gap();
    int s0;
    wr(15'h0020, 8'h31, 1, "R7 gap b0");
    s0 = n_start;
    idle(WIN - 1);
    wr(15'h0021, 8'h32, 1, "R7 gap edge write");
    chk(n_start == s0, "R7 no close before gap write", n_start, s0);
    close_chk(1, "R7 gap");
    done_pulse();
  endtask

  task automatic t_enable();
    wr(15'h5555, 8'hAA, 0, "R3 arm s1");
    wr(15'h2AAA, 8'h55, 0, "R3 arm s2");
    wr(15'h5555, 8'hA0, 0, "R3 arm s3");
    wr(15'h1234, 8'h5A, 1, "R3 arm data");
    close_chk(1, "R3 arm");
    chk(prot_on == 0, "R4 prot unchanged while busy", prot_on, 0);
    idle(3);
    chk(prot_on == 0, "R4 prot unchanged late", prot_on, 0);
    done_pulse();
    chk(prot_on == 1, "R4 prot set at done", prot_on, 1);
  endtask

  task automatic t_blocked();
    wr(15'h0100, 8'h33, 0, "R6 protected write");
    wr(15'h0101, 8'h34, 0, "R6 protected write2");
    close_chk(0, "R6 blind");
    done_pulse();
    chk(prot_on == 1, "R6 prot kept", prot_on, 1);
  endtask

  task automatic t_unlock_protected();
    wr(15'h5555, 8'hAA, 0, "R3 re-arm s1");
    wr(15'h2AAA, 8'h55, 0, "R3 re-arm s2");
    wr(15'h5555, 8'hA0, 0, "R3 re-arm s3");
    wr(15'h5555, 8'h77, 1, "R3 data to command address");
    close_chk(1, "R3 unlocked commit");
    done_pulse();
    chk(prot_on == 1, "R4 prot stays on", prot_on, 1);
  endtask

  task automatic t_mismatch_prot();
    wr(15'h5555, 8'hAA, 0, "R9 prot s1");
    wr(15'h1111, 8'h55, 0, "R9 prot mismatch dropped");
    wr(15'h5555, 8'hA0, 0, "R9 prot after mismatch");
    close_chk(0, "R9 prot");
    done_pulse();
    chk(prot_on == 1, "R9 prot unchanged", prot_on, 1);
  endtask

  task automatic t_disable();
    wr(15'h5555, 8'hAA, 0, "R5 d1");
    wr(15'h2AAA, 8'h55, 0, "R5 d2");
    wr(15'h5555, 8'h80, 0, "R5 d3");
    wr(15'h5555, 8'hAA, 0, "R5 d4");
    wr(15'h2AAA, 8'h55, 0, "R5 d5");
    wr(15'h5555, 8'h20, 0, "R5 d6");
    close_chk(0, "R5 blind");
    chk(prot_on == 1, "R5 prot held while busy", prot_on, 1);
    done_pulse();
    chk(prot_on == 0, "R5 prot cleared at done", prot_on, 0);
  endtask

  task automatic t_partial();
    wr(15'h5555, 8'hAA, 0, "R8 partial s1");
    close_chk(0, "R8 partial timeout");
    done_pulse();
    wr(15'h2AAA, 8'h55, 1, "R8 restart as data");
    wr(15'h5555, 8'hA0, 1, "R8 tail as data");
    close_chk(1, "R8 data phase");
    done_pulse();
    chk(prot_on == 0, "R8 no protection", prot_on, 0);
  endtask

  task automatic t_mismatch_unprot();
    wr(15'h5555, 8'hAA, 0, "R9 s1");
    wr(15'h2AAA, 8'h55, 0, "R9 s2");
    wr(15'h5555, 8'h77, 1, "R9 mismatch stored");
    close_chk(1, "R9 unprot");
    done_pulse();
    chk(prot_on == 0, "R9 no protection", prot_on, 0);
  endtask

  task automatic t_first_only();
    wr(15'h0000, 8'h11, 1, "R12 lead data");
    wr(15'h5555, 8'hAA, 1, "R12 key as data");
    wr(15'h2AAA, 8'h55, 1, "R12 key2 as data");
    wr(15'h5555, 8'hA0, 1, "R12 arm as data");
    close_chk(1, "R12");
    done_pulse();
    chk(prot_on == 0, "R12 no protection", prot_on, 0);
  endtask

  task automatic t_backpressure();
    wr(15'h0001, 8'h01, 1, "R10 lead");
    close_chk(1, "R10");
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 15'h0002; wr_data = 8'h02;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(!st_valid && !wr_ready, "R10 held request refused", {st_valid, wr_ready}, 0);
    end
    @(negedge clk); wr_valid = 1'b0;
    done_pulse();
    done_pulse();
    chk(wr_ready == 1 && prot_on == 0 && !st_valid, "R10 stray done ignored",
        {wr_ready, prot_on, st_valid}, 3'b100);
    idle(2 * WIN);
    chk(!commit_start && !blind_start, "R10 no phase from stray done",
        {commit_start, blind_start}, 0);
    wr(15'h0003, 8'h03, 1, "R10 port works again");
    close_chk(1, "R10 after");
    done_pulse();
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_plain();
    t_gap();
    t_enable();
    t_blocked();
    t_unlock_protected();
    t_mismatch_prot();
    t_disable();
    t_partial();
    t_mismatch_unprot();
    t_first_only();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule